// File: doc/BRIEF.md
# Dual Redundant Controller Selector

This block decides which of two redundant controllers is allowed to drive a shared set of outputs. Each controller is watched by its own watchdog, which hands the selector two flags: a sticky failure flag that stays set once a failure has been seen, and a live alarm flag that is high only while the watchdog currently sees a fault. A manual override lets an operator force either controller.

The result is a single registered select bit (0 picks controller one, 1 picks controller two), so exactly one controller is active in every cycle. Decisions follow a fixed priority. The manual override wins. Next comes the case where both controllers have failed, which is settled by the live alarms. If the alarms cannot tell the two apart, an internal 8-bit LFSR makes a pseudo-random pick. That pick is sampled once, when the tie first appears, and then held. After that comes single-failure failover. With no failures at all, the initial controller set by a parameter is used.

All inputs are plain level signals. The select output changes one clock after the inputs that cause it. There is no data stream and therefore no valid/ready handshake.

Top module: `redundant_ctrl_selector`

## Requirements
- R1: While the synchronous reset `rst` is high, the select is forced to the INIT_SEL parameter (default 0, controller one) at each clock, whatever the other inputs do. Outside reset, `sel` reflects the inputs one clock edge earlier.
- R2: When `force_en` is 1, `sel` becomes `force_pick` at the next edge, regardless of any failure or alarm input.
- R3: With `force_en` 0 and neither sticky failure flag set, `sel` becomes INIT_SEL.
- R4: With `force_en` 0 and only one sticky failure flag set, `sel` selects the other controller: `failed_one` alone gives 1, and `failed_two` alone gives 0.
- R5: With `force_en` 0 and both sticky flags set, if exactly one live alarm is high, `sel` picks the controller whose alarm is low: `alarm_one` alone high gives 1, and `alarm_two` alone high gives 0.
- R6: With `force_en` 0, both sticky flags set and both alarms equal, the condition is a tie. At the first edge of a tie, `sel` takes bit 0 of an LFSR state `s`. `s` is loaded with 8'hA5 during reset. At every later edge it shifts left, and the new bit 0 equals s[7]^s[5]^s[4]^s[3] (polynomial x^8+x^6+x^5+x^4+1), so the state is never zero.
- R7: While a tie persists on consecutive edges, `sel` holds its value. Once the tie is broken for at least one edge, the next tie samples the LFSR afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| failed_one | input | 1 | Sticky failure flag of controller one |
| failed_two | input | 1 | Sticky failure flag of controller two |
| alarm_one | input | 1 | Live alarm of controller one (1 = currently faulty) |
| alarm_two | input | 1 | Live alarm of controller two (1 = currently faulty) |
| force_en | input | 1 | Manual override enable |
| force_pick | input | 1 | Controller forced while override is enabled (0 = one, 1 = two) |
| sel | output | 1 | Active controller (0 = one, 1 = two) |

## Verification
The hardest situation to reach from the ports is the tie. Its outcome depends on the LFSR state at the exact entry edge, and the LFSR state cannot be observed. The bench runs its own model of the register from the release of reset, counting every clock. It enters a tie at a chosen negative edge, predicts the select from the model's bit 0 at that moment, and then holds the tie over many clocks to show that the pick does not follow the still-running LFSR. It also breaks and re-enters the tie repeatedly, so that new samples are taken and both possible picks appear.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

  typedef enum logic {
    CTRL_ONE = 1'b0,
    CTRL_TWO = 1'b1
  } ctrl_id_e;

  typedef enum logic [2:0] {
    WHY_FORCED,
    WHY_NOMINAL,
    WHY_FAILOVER,
    WHY_LIVE,
    WHY_DRAW,
    WHY_HOLD
  } why_e;

  typedef struct packed {
    ctrl_id_e pick;
    why_e     why;
    logic     tie;
  } decision_t;

endpackage

// File: rtl/rsel_lfsr.sv
module rsel_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAPS = 8'b1011_1000,
  parameter logic [W-1:0] SEED = 8'hA5
) (
  input  logic clk,
  input  logic rst,
  output logic rnd_bit
);

  logic [W-1:0] state_q;
  logic         fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= {state_q[W-2:0], fb};
  end

  assign rnd_bit = state_q[0];

  // R6: a maximal-length register with a nonzero seed never reaches zero
  a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

endmodule

// File: rtl/rsel_arbiter.sv
module rsel_arbiter
  import rsel_pkg::*;
#(
  parameter ctrl_id_e INIT_SEL = CTRL_ONE
) (
  input  logic      force_en,
  input  logic      force_pick,
  input  logic [1:0] failed,
  input  logic [1:0] alarm,
  input  ctrl_id_e  cur_sel,
  input  logic      tie_prev,
  input  logic      rnd_bit,
  output decision_t dec
);

  logic both_failed;
  logic live_split;

  assign both_failed = failed[0] & failed[1];
  assign live_split  = alarm[0] ^ alarm[1];

  always_comb begin
    dec.pick = INIT_SEL;
    dec.why  = WHY_NOMINAL;
    dec.tie  = 1'b0;
    if (force_en) begin
      dec.pick = ctrl_id_e'(force_pick);
      dec.why  = WHY_FORCED;
    end else if (both_failed) begin
      if (live_split) begin
        dec.pick = alarm[0] ? CTRL_TWO : CTRL_ONE;
        dec.why  = WHY_LIVE;
      end else begin
        dec.tie = 1'b1;
        if (tie_prev) begin
          dec.pick = cur_sel;
          dec.why  = WHY_HOLD;
        end else begin
          dec.pick = ctrl_id_e'(rnd_bit);
          dec.why  = WHY_DRAW;
        end
      end
    end else if (failed[0]) begin
      dec.pick = CTRL_TWO;
      dec.why  = WHY_FAILOVER;
    end else if (failed[1]) begin
      dec.pick = CTRL_ONE;
      dec.why  = WHY_FAILOVER;
    end
  end

  // R5: a live-status decision never selects the controller raising an alarm
  always_comb begin
    if (dec.why == WHY_LIVE) begin
      a_r5_live_healthy: assert (alarm[dec.pick] == 1'b0);
    end
  end

endmodule

// File: rtl/redundant_ctrl_selector.sv
module redundant_ctrl_selector
  import rsel_pkg::*;
#(
  parameter ctrl_id_e         INIT_SEL = CTRL_ONE,
  parameter int unsigned      LFSR_W   = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'b1011_1000,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'hA5
) (
  input  logic clk,
  input  logic rst,
  input  logic failed_one,
  input  logic failed_two,
  input  logic alarm_one,
  input  logic alarm_two,
  input  logic force_en,
  input  logic force_pick,
  output logic sel
);

  ctrl_id_e  sel_q;
  logic      tie_q;
  logic      rnd_bit;
  decision_t dec;

  rsel_lfsr #(
    .W   (LFSR_W),
    .TAPS(LFSR_TAPS),
    .SEED(LFSR_SEED)
  ) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .rnd_bit(rnd_bit)
  );

  rsel_arbiter #(
    .INIT_SEL(INIT_SEL)
  ) u_arb (
    .force_en  (force_en),
    .force_pick(force_pick),
    .failed    ({failed_two, failed_one}),
    .alarm     ({alarm_two, alarm_one}),
    .cur_sel   (sel_q),
    .tie_prev  (tie_q),
    .rnd_bit   (rnd_bit),
    .dec       (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= INIT_SEL;
      tie_q <= 1'b0;
    end else begin
      sel_q <= dec.pick;
      tie_q <= dec.tie;
    end
  end

  assign sel = sel_q;

  // R1: reset forces the initial controller
  a_r1_reset_init: assert property (@(posedge clk)
    rst |=> sel == INIT_SEL);

  // R2: override wins over everything
  a_r2_force_follow: assert property (@(posedge clk) disable iff (rst)
    force_en |=> sel == $past(force_pick));

  // R3: no latched failures keeps the initial controller
  a_r3_nominal: assert property (@(posedge clk) disable iff (rst)
    (!force_en && !failed_one && !failed_two) |=> sel == INIT_SEL);

  // R4: single failure moves to the other controller
  a_r4_failover_one: assert property (@(posedge clk) disable iff (rst)
    (!force_en && failed_one && !failed_two) |=> sel == 1'b1);
  a_r4_failover_two: assert property (@(posedge clk) disable iff (rst)
    (!force_en && !failed_one && failed_two) |=> sel == 1'b0);

  // R7: a persisting tie holds the earlier pick
  a_r7_tie_hold: assert property (@(posedge clk) disable iff (rst)
    (tie_q && !force_en && failed_one && failed_two && (alarm_one == alarm_two))
      |=> sel == $past(sel));

endmodule

// File: tb/tb_redundant_ctrl_selector.sv
`timescale 1ns/1ps
module tb_redundant_ctrl_selector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic failed_one = 1'b0, failed_two = 1'b0;
  logic alarm_one = 1'b0, alarm_two = 1'b0;
  logic force_en = 1'b0, force_pick = 1'b0;
  logic sel;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  int cycles = 0;
  logic [7:0] model;
  bit seen0 = 1'b0, seen1 = 1'b0;

  always #2.5 clk = ~clk;

  redundant_ctrl_selector dut (
    .clk(clk), .rst(rst),
    .failed_one(failed_one), .failed_two(failed_two),
    .alarm_one(alarm_one), .alarm_two(alarm_two),
    .force_en(force_en), .force_pick(force_pick),
    .sel(sel)
  );

  // independent model of the random source as stated in R6
  always @(posedge clk) begin
    if (rst) model <= 8'hA5;
    else     model <= {model[6:0], model[7] ^ model[5] ^ model[4] ^ model[3]};
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual sel=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic fe, fp, f1, f2, a1, a2);
    force_en = fe; force_pick = fp;
    failed_one = f1; failed_two = f2;
    alarm_one = a1; alarm_two = a2;
  endtask

  task automatic t_r1_reset();
    @(negedge clk);
    rst = 1'b1;
    drive(1, 1, 1, 0, 1, 0);
    @(negedge clk);
    check("R1 reset forces init", sel, 1'b0);
    drive(0, 0, 0, 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", sel, 1'b0);
  endtask

  task automatic t_r3_nominal();
    drive(0, 1, 0, 0, 1, 1);
    @(negedge clk);
    check("R3 no failures, alarms ignored", sel, 1'b0);
  endtask

  task automatic t_r4_failover();
    drive(0, 0, 1, 0, 0, 0);
    @(negedge clk);
    check("R4 one failed -> two", sel, 1'b1);
    drive(0, 0, 0, 1, 0, 0);
    @(negedge clk);
    check("R4 two failed -> one", sel, 1'b0);
    drive(0, 0, 1, 0, 1, 0);
    @(negedge clk);
    check("R4 one failed with alarm -> two", sel, 1'b1);
  endtask

  task automatic t_r5_live();
    drive(0, 0, 1, 1, 1, 0);
    @(negedge clk);
    check("R5 both failed, alarm one -> two", sel, 1'b1);
    drive(0, 0, 1, 1, 0, 1);
    @(negedge clk);
    check("R5 both failed, alarm two -> one", sel, 1'b0);
  endtask

  task automatic t_r2_force();
    drive(1, 1, 0, 0, 0, 0);
    @(negedge clk);
    check("R2 force two over nominal", sel, 1'b1);
    drive(1, 0, 1, 0, 0, 0);
    @(negedge clk);
    check("R2 force one over failover", sel, 1'b0);
    drive(1, 1, 1, 1, 0, 1);
    @(negedge clk);
    check("R2 force two over live decision", sel, 1'b1);
  endtask

  task automatic t_r6_r7_tie();
    for (int k = 0; k < 12; k++) begin
      logic exp;
      drive(0, 0, 1, 1, k[0], k[0]);
      exp = model[0];
      @(negedge clk);
      check("R6 tie entry samples LFSR bit0", sel, exp);
      if (exp) seen1 = 1'b1; else seen0 = 1'b1;
      for (int h = 0; h < 5 + k; h++) begin
        @(negedge clk);
        check("R7 tie holds pick", sel, exp);
      end
      drive(0, 0, 1, 1, ~exp, exp);
      @(negedge clk);
      check("R5 tie broken by live status", sel, ~exp);
    end
    vectors++;
    if (!(seen0 && seen1)) begin
      miscompares++;
      $display("FAIL R6: actual picks seen0=%b seen1=%b expected both 1", seen0, seen1);
    end
  endtask

  task automatic t_r7_force_breaks_tie();
    logic exp;
    drive(0, 0, 1, 1, 1, 1);
    exp = model[0];
    @(negedge clk);
    check("R6 tie entry", sel, exp);
    drive(1, ~exp, 1, 1, 1, 1);
    @(negedge clk);
    check("R2 force during tie", sel, ~exp);
    drive(0, 0, 1, 1, 1, 1);
    exp = model[0];
    @(negedge clk);
    check("R7 re-entry after force samples anew", sel, exp);
  endtask

  initial begin
    t_r1_reset();
    t_r3_nominal();
    t_r4_failover();
    t_r5_live();
    t_r2_force();
    t_r6_r7_tie();
    t_r7_force_breaks_tie();
    t_r1_reset();
    t_r6_r7_tie();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule